// File: doc/BRIEF.md
# Flag-Handshake Sample Stream Source

This block sits between a slow producer of 32-bit samples and a fixed-address read port that a DMA engine polls. Each sample offered by the producer through a valid/data pair is captured into a single output word register. The lowest two bits of that word are overwritten with a rolling tag so that a consumer can detect a repeated or missing word. The block then pulls an active-low data-ready flag low and waits for the reader's active-low read strobe.

The strobe comes from another timing domain. It passes through a synchronizer and a falling-edge detector, and the block accepts one read per low pulse. The flag is released on the first clock edge after the synchronized falling edge, never on an edge of the raw strobe. A start pulse loads the packet length, which is clamped to a parameterized range (1024 to 11264 words by default), and arms the block. When the last word of the packet has been read, the block disarms and raises a done flag. A sample that arrives while a word is still unread is not written over the held word; it sets a sticky overrun flag.

Top module: `dav_stream_src`

## Requirements
- R1: After a synchronous active-high reset, `dav_n_o` is 1 and `overrun_o` and `done_o` are 0. The block is unarmed.
- R2: A `start_i` pulse loads `pkt_len_i` and arms the block. The length is clamped to at least MIN_LEN (1024) and at most MAX_LEN (11264). The pulse also clears the tag, the pending word, `overrun_o` and `done_o`.
- R3: When the block is armed and `smp_valid_i` is high with no word pending, then on the next cycle `dav_n_o` is 0 and `rd_data_o` equals `smp_data_i[31:2]` followed by the 2-bit tag in bits [1:0].
- R4: The first word captured after a start carries tag 0. Each further captured word carries the previous tag plus one, modulo 4.
- R5: Let `rd_n_i` fall low just before clock edge 1. The read is accepted on edge 3, which is two synchronizer stages plus the edge detector. `dav_n_o` is still 0 after edge 2 and is 1 after edge 3.
- R6: The block accepts at most one read per low pulse of `rd_n_i`, however long the pulse lasts. A low pulse while no word is pending has no effect, and no tag value is skipped as a result.
- R7: `rd_data_o` does not change while a word is pending and not yet accepted.
- R8: A `smp_valid_i` that arrives while a word is pending sets `overrun_o`, and the held word is kept. `overrun_o` stays 1 until the next reset or start.
- R9: `done_o` rises on the same edge that accepts the read of the packet's last word. The block then disarms, `dav_n_o` stays 1, and no word is counted short of the programmed length.
- R10: `smp_valid_i` is ignored while the block is unarmed, before the first start and after done: `dav_n_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: load length and arm |
| pkt_len_i | input | 14 | Packet length in words, clamped to the allowed range |
| smp_valid_i | input | 1 | Producer sample strobe |
| smp_data_i | input | 32 | Producer sample value |
| rd_n_i | input | 1 | Active-low read strobe, asynchronous to clk |
| dav_n_o | output | 1 | Active-low data-ready flag |
| rd_data_o | output | 32 | Held word: upper bits are the sample, bits [1:0] are the tag |
| overrun_o | output | 1 | Sticky: a sample arrived while a word was unread |
| done_o | output | 1 | Last word of the packet has been read |

## Verification
The hardest situations to reach from the ports are the boundaries of a full packet. The done flag must rise exactly on the final accepted read and not one word early. Its length is at least 1024 words, so the bench streams two whole packets with cheap handshakes. One packet uses a length below the minimum, to check the clamp. The other uses an unclamped length of 1030 words, checked just before and at its last read. A second hard case is a read strobe held low across the arrival of a new sample. The bench holds the strobe low, offers a sample after the first word is taken, and confirms that the new word stays offered until the strobe rises and falls again.

// File: rtl/dav_pkg.sv
package dav_pkg;
  localparam int DEF_WORD_W = 32;
  localparam int DEF_TAG_W  = 2;

  // Advance the rolling tag by one, wrapping naturally at its width.
  function automatic logic [DEF_TAG_W-1:0] tag_step(input logic [DEF_TAG_W-1:0] t);
    return t + 1'b1;
  endfunction

  // Replace the low tag bits of a sample with the tag.
  function automatic logic [DEF_WORD_W-1:0] tag_word(input logic [DEF_WORD_W-1:0] d,
                                                     input logic [DEF_TAG_W-1:0]  t);
    return {d[DEF_WORD_W-1:DEF_TAG_W], t};
  endfunction
endpackage

// File: rtl/rd_strobe_sync.sv
module rd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_n_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= rd_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[STAGES-2:0], rd_n_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= sync_q[STAGES-1];
  end

  // One-cycle pulse on a high-to-low transition of the synchronized strobe.
  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/pkt_counter.sv
module pkt_counter #(
  parameter int MIN_LEN = 1024,
  parameter int MAX_LEN = 11264,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             accept_i,
  output logic             armed_o,
  output logic             done_o
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    if (l < MIN_L) return MIN_L;
    if (l > MAX_L) return MAX_L;
    return l;
  endfunction

  logic [LEN_W-1:0] left_q;
  logic             armed_q;
  logic             done_q;
  logic             final_w;

  assign final_w = armed_q && accept_i && (left_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      left_q  <= clamp_len(len_i);
      armed_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (armed_q && accept_i) begin
      left_q <= left_q - 1'b1;
      if (final_w) begin
        armed_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sample_holder.sv
module sample_holder
  import dav_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int TAG_W  = DEF_TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              armed_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              accept_i,
  output logic [WORD_W-1:0] word_o,
  output logic              pending_o,
  output logic              overrun_o,
  output logic              capture_o,
  output logic              overrun_evt_o
);
  logic [WORD_W-1:0] word_q;
  logic [TAG_W-1:0]  tag_q;
  logic              pending_q;
  logic              overrun_q;

  assign capture_o     = armed_i && valid_i && !pending_q;
  assign overrun_evt_o = armed_i && valid_i && pending_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      word_q    <= '0;
      tag_q     <= '0;
      pending_q <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      if (capture_o) begin
        word_q    <= tag_word(data_i, tag_q);
        tag_q     <= tag_step(tag_q);
        pending_q <= 1'b1;
      end else if (accept_i) begin
        pending_q <= 1'b0;
      end
      if (overrun_evt_o) overrun_q <= 1'b1;
    end
  end

  assign word_o    = word_q;
  assign pending_o = pending_q;
  assign overrun_o = overrun_q;
endmodule

// File: rtl/dav_stream_src.sv
module dav_stream_src #(
  parameter int WORD_W      = 32,
  parameter int TAG_W       = 2,
  parameter int MIN_LEN     = 1024,
  parameter int MAX_LEN     = 11264,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic              smp_valid_i,
  input  logic [WORD_W-1:0] smp_data_i,
  input  logic              rd_n_i,
  output logic              dav_n_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              overrun_o,
  output logic              done_o
);
  // Named internal events, observed by the bound checker.
  logic rd_fall_w;
  logic accept_w;
  logic capture_w;
  logic overrun_evt_w;
  logic pending_w;
  logic armed_w;

  rd_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .rd_n_i (rd_n_i),
    .fall_o (rd_fall_w)
  );

  // A read counts only when a word is waiting.
  assign accept_w = rd_fall_w && pending_w && !start_i;

  pkt_counter #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .len_i    (pkt_len_i),
    .accept_i (accept_w),
    .armed_o  (armed_w),
    .done_o   (done_o)
  );

  sample_holder #(.WORD_W(WORD_W), .TAG_W(TAG_W)) hold_i (
    .clk           (clk),
    .rst           (rst),
    .clear_i       (start_i),
    .armed_i       (armed_w),
    .valid_i       (smp_valid_i),
    .data_i        (smp_data_i),
    .accept_i      (accept_w),
    .word_o        (rd_data_o),
    .pending_o     (pending_w),
    .overrun_o     (overrun_o),
    .capture_o     (capture_w),
    .overrun_evt_o (overrun_evt_w)
  );

  assign dav_n_o = ~pending_w;
endmodule

// File: rtl/dav_stream_chk.sv
module dav_stream_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              dav_n_o,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              overrun_o,
  input logic              done_o,
  input logic              rd_fall_w,
  input logic              accept_w,
  input logic              capture_w,
  input logic              overrun_evt_w
);
  // R3
  capture_offer_chk: assert property (@(posedge clk) disable iff (rst)
    (capture_w && !start_i) |=> !dav_n_o);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> dav_n_o);

  // R6
  single_fall_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fall_w |=> !rd_fall_w);

  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    (!dav_n_o && !accept_w && !start_i) |=> (!dav_n_o && $stable(rd_data_o)));

  // R8
  overrun_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun_evt_w && !start_i) |=> (overrun_o && $stable(rd_data_o)));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !start_i) |=> overrun_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> dav_n_o);
endmodule

bind dav_stream_src dav_stream_chk #(.WORD_W(WORD_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .dav_n_o       (dav_n_o),
  .rd_data_o     (rd_data_o),
  .overrun_o     (overrun_o),
  .done_o        (done_o),
  .rd_fall_w     (rd_fall_w),
  .accept_w      (accept_w),
  .capture_w     (capture_w),
  .overrun_evt_w (overrun_evt_w)
);

// File: tb/dav_stream_src_tb_top.sv
`timescale 1ns/1ps
module dav_stream_src_tb_top;
  localparam int LEN_W = 14;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [LEN_W-1:0]  pkt_len_i = '0;
  logic              smp_valid_i = 1'b0;
  logic [31:0]       smp_data_i = '0;
  logic              rd_n_i = 1'b1;
  logic              dav_n_o;
  logic [31:0]       rd_data_o;
  logic              overrun_o;
  logic              done_o;

  int tests = 0;
  int fails = 0;
  int words_read = 0;
  logic [1:0] tag_exp = 2'd0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dav_stream_src dut_i (
    .clk (clk), .rst (rst), .start_i (start_i), .pkt_len_i (pkt_len_i),
    .smp_valid_i (smp_valid_i), .smp_data_i (smp_data_i), .rd_n_i (rd_n_i),
    .dav_n_o (dav_n_o), .rd_data_o (rd_data_o), .overrun_o (overrun_o), .done_o (done_o)
  );

  // {extra low-hold cycles, sample value}
  localparam logic [39:0] VEC [0:7] = '{
    40'h00_DEADBEEF, 40'h01_12345677, 40'h05_FFFFFFFF, 40'h00_00000000,
    40'h0A_A5A5A5A6, 40'h02_80000001, 40'h00_7FFFFFFC, 40'h03_0F0F0F0F
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] d, input logic [1:0] t);
    return (d & 32'hFFFF_FFFC) | {30'd0, t};
  endfunction

  task automatic push(input logic [31:0] d);
    @(negedge clk); smp_valid_i = 1'b1; smp_data_i = d;
    @(negedge clk); smp_valid_i = 1'b0;
  endtask

  // Full read with timing checks on the release edge.
  task automatic read_word(input int hold);
    @(negedge clk); rd_n_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(dav_n_o == 1'b0, "R5 flag still low after two edges", {31'd0, dav_n_o}, 32'd0);
    @(negedge clk);
    chk(dav_n_o == 1'b1, "R5 flag released on third edge", {31'd0, dav_n_o}, 32'd1);
    repeat (hold) @(negedge clk);
    rd_n_i = 1'b1;
    repeat (3) @(negedge clk);
    words_read++;
  endtask

  task automatic quick_read();
    @(negedge clk); rd_n_i = 1'b0;
    repeat (3) @(negedge clk);
    rd_n_i = 1'b1;
    repeat (3) @(negedge clk);
    words_read++;
  endtask

  task automatic quick_word(input logic [31:0] d);
    push(d);
    quick_read();
    tag_exp = tag_exp + 2'd1;
  endtask

  task automatic do_start(input logic [LEN_W-1:0] len);
    @(negedge clk); start_i = 1'b1; pkt_len_i = len;
    @(negedge clk); start_i = 1'b0;
    tag_exp = 2'd0;
    words_read = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dav_n_o == 1'b1, "R1 flag high after reset", {31'd0, dav_n_o}, 32'd1);
    chk(overrun_o == 1'b0, "R1 overrun clear after reset", {31'd0, overrun_o}, 32'd0);
    chk(done_o == 1'b0, "R1 done clear after reset", {31'd0, done_o}, 32'd0);

    // R10 sample ignored while unarmed
    push(32'h1111_1111);
    @(negedge clk);
    chk(dav_n_o == 1'b1, "R10 sample ignored before start", {31'd0, dav_n_o}, 32'd1);

    // R2 start with length below minimum (clamped to 1024)
    do_start(14'd3);

    // R6 strobe with nothing pending has no effect
    @(negedge clk); rd_n_i = 1'b0;
    repeat (4) @(negedge clk); rd_n_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(dav_n_o == 1'b1, "R6 idle strobe leaves flag high", {31'd0, dav_n_o}, 32'd1);

    // Vector table: capture, tag, release timing
    for (int i = 0; i < 8; i++) begin
      logic [31:0] d;
      d = VEC[i][31:0];
      push(d);
      chk(dav_n_o == 1'b0, "R3 flag low after capture", {31'd0, dav_n_o}, 32'd0);
      chk(rd_data_o == expect_word(d, tag_exp), "R3 R4 word and tag", rd_data_o, expect_word(d, tag_exp));
      repeat (3) @(negedge clk);
      chk(rd_data_o == expect_word(d, tag_exp), "R7 word held while pending", rd_data_o, expect_word(d, tag_exp));
      read_word(int'(VEC[i][39:32]));
      tag_exp = tag_exp + 2'd1;
    end

    // R6 long low pulse: one accept only, new word stays offered
    push(32'hCAFE_0000);
    @(negedge clk); rd_n_i = 1'b0;
    repeat (3) @(negedge clk);
    words_read++;
    tag_exp = tag_exp + 2'd1;
    chk(dav_n_o == 1'b1, "R6 first word taken", {31'd0, dav_n_o}, 32'd1);
    push(32'hBEEF_0003);
    repeat (6) @(negedge clk);
    chk(dav_n_o == 1'b0, "R6 held-low strobe does not take second word", {31'd0, dav_n_o}, 32'd0);
    chk(rd_data_o == expect_word(32'hBEEF_0003, tag_exp), "R6 R4 second word intact",
        rd_data_o, expect_word(32'hBEEF_0003, tag_exp));
    rd_n_i = 1'b1;
    repeat (3) @(negedge clk);
    read_word(0);
    tag_exp = tag_exp + 2'd1;

    // R8 overrun keeps older word
    push(32'h0000_1230);
    push(32'h0000_4560);
    chk(overrun_o == 1'b1, "R8 overrun raised", {31'd0, overrun_o}, 32'd1);
    chk(rd_data_o == expect_word(32'h0000_1230, tag_exp), "R8 older word kept",
        rd_data_o, expect_word(32'h0000_1230, tag_exp));
    read_word(0);
    tag_exp = tag_exp + 2'd1;
    chk(overrun_o == 1'b1, "R8 overrun sticky after read", {31'd0, overrun_o}, 32'd1);

    // R9 finish the clamped 1024-word packet
    while (words_read < 1023) quick_word(32'h5555_0000 + words_read);
    chk(done_o == 1'b0, "R9 R2 not done one word early", {31'd0, done_o}, 32'd0);
    push(32'h9999_9998);
    chk(rd_data_o == expect_word(32'h9999_9998, tag_exp), "R4 tag at last word",
        rd_data_o, expect_word(32'h9999_9998, tag_exp));
    quick_read();
    chk(done_o == 1'b1, "R9 done after last word", {31'd0, done_o}, 32'd1);
    chk(dav_n_o == 1'b1, "R9 flag high at done", {31'd0, dav_n_o}, 32'd1);
    push(32'h7777_7777);
    @(negedge clk);
    chk(dav_n_o == 1'b1, "R10 R9 sample ignored after done", {31'd0, dav_n_o}, 32'd1);

    // R2 restart clears flags and tag, unclamped length 1030
    do_start(14'd1030);
    chk(overrun_o == 1'b0, "R2 start clears overrun", {31'd0, overrun_o}, 32'd0);
    chk(done_o == 1'b0, "R2 start clears done", {31'd0, done_o}, 32'd0);
    push(32'hABCD_EF03);
    chk(rd_data_o == expect_word(32'hABCD_EF03, 2'd0), "R2 R4 tag restarts at zero",
        rd_data_o, expect_word(32'hABCD_EF03, 2'd0));
    quick_read();
    tag_exp = tag_exp + 2'd1;
    while (words_read < 1029) quick_word(32'h3333_0000 + words_read);
    chk(done_o == 1'b0, "R2 no done at 1029 of 1030", {31'd0, done_o}, 32'd0);
    quick_word(32'h4444_4444);
    chk(done_o == 1'b1, "R2 R9 done at 1030", {31'd0, done_o}, 32'd1);

    // R1 reset clears state again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0 && dav_n_o == 1'b1, "R1 reset after packet", {30'd0, done_o, dav_n_o}, 32'd1);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule